// File: doc/BRIEF.md
# Multi-Channel Gamma Correction Table

This block corrects the colour of 24-bit RGB pixels for several display channels. Each channel has its own curve for each of red, green and blue. Every curve is a table of 256 eight-bit entries. All the curves sit in one flat address space, and software reaches that space through a pair of registers. The first register sets an address and an auto-advance flag. The second register takes data. With the flag set, software can send a whole curve as a run of data writes with no address writes between them.

Pixels arrive on a valid/ready port together with a channel index. Each of the three components indexes its own curve, and the corrected pixel leaves two clock edges after it is accepted. Each channel has an enable input. When a channel's enable is low, that channel's pixels pass through unchanged. After reset every curve maps each value to itself, so turning on correction changes nothing until software loads new curves.

Top module: `gamma_lut`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and every table entry at index i holds the value i. An enabled channel therefore returns its input pixel unchanged.
- R2: The table address of an entry is channel*768 + component*256 + index, where component 0 is red, 1 is green and 2 is blue. A pixel is packed as red in bits [23:16], green in [15:8] and blue in [7:0]. For an enabled channel, each output component is the table entry that the input component indexes.
- R3: A write with cfg_sel=0 loads the address from cfg_wdata[14:0] and the auto-advance flag from cfg_wdata[15]. With the flag set, a write with cfg_sel=1 stores cfg_wdata[7:0] at the current address and then adds one to the address.
- R4: With the auto-advance flag clear, a data write stores to the current address and leaves the address unchanged, so later data writes overwrite the same entry.
- R5: A data write at an address of 2304 or higher changes no entry and does not advance the address. An auto-advancing stream therefore stops at the last entry, 2303, and never wraps to entry 0.
- R6: When gamma_en[c] is 0, a pixel on channel c leaves unchanged. A pixel whose channel index is 3 or higher also leaves unchanged.
- R7: A pixel accepted at clock edge k appears on out_pixel with out_valid=1 after edge k+2, provided out_ready was high. One pixel can be accepted on every edge.
- R8: in_ready equals out_ready OR NOT out_valid. While out_valid=1 and out_ready=0, out_valid and out_pixel hold their values.
- R9: The lookup for a pixel happens at the edge after it is accepted. A table write at that same edge does not affect that pixel, which gets the old entry. The next pixel gets the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 = address register, 1 = data register |
| cfg_wdata | input | 16 | Write data: [15] auto-advance and [14:0] address, or [7:0] table entry |
| gamma_en | input | 3 | Per-channel correction enable |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can take a pixel |
| in_chan | input | 2 | Channel of the input pixel |
| in_pixel | input | 24 | Input pixel, red in the top byte |
| out_valid | output | 1 | Corrected pixel valid |
| out_ready | input | 1 | Consumer takes the pixel |
| out_pixel | output | 24 | Corrected pixel |

## Verification
A table write and a pixel lookup can land on the same entry at the same clock edge. The bench provokes this on purpose. It accepts a pixel, then at the very next edge issues a data write to the entry that pixel indexes. It then expects the old entry on the output and the new entry for the pixel that follows. Random streams run with an irregular out_ready and are checked against a reference copy of the table. Those streams separately show that stalls never corrupt or drop pixels.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;

  // Colour components in table order; the order sets the address layout.
  typedef enum logic [1:0] {
    COMP_RED   = 2'd0,
    COMP_GREEN = 2'd1,
    COMP_BLUE  = 2'd2
  } comp_e;

  localparam int NUM_COMP = 3;

  // Register select encoding.
  localparam logic SEL_ADDR = 1'b0;
  localparam logic SEL_DATA = 1'b1;

endpackage

// File: rtl/gamma_lut_regs.sv
module gamma_lut_regs
  import gamma_lut_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DEPTH  = 256,
  parameter int CW     = 8,
  parameter int CFG_W  = 16,
  localparam int AW    = CFG_W - 1,
  localparam int BIW   = $clog2(NUM_CH * DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             wr_en,
  output logic [1:0]       wr_comp,
  output logic [BIW-1:0]   wr_index,
  output logic [CW-1:0]    wr_data
);

  localparam int CH_SPAN = NUM_COMP * DEPTH;
  localparam int TOTAL   = NUM_CH * CH_SPAN;

  logic [AW-1:0] addr_q, addr_d;
  logic          inc_q, inc_d;
  logic          in_range;
  logic          data_wr;

  assign in_range = (32'(addr_q) < TOTAL);
  assign data_wr  = cfg_wr && (cfg_sel == SEL_DATA);

  always_comb begin
    addr_d = addr_q;
    inc_d  = inc_q;
    if (cfg_wr && (cfg_sel == SEL_ADDR)) begin
      addr_d = cfg_wdata[AW-1:0];
      inc_d  = cfg_wdata[CFG_W-1];
    end else if (data_wr && in_range && inc_q) begin
      addr_d = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      inc_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      inc_q  <= inc_d;
    end
  end

  // Split the flat address into component bank and index inside the bank.
  always_comb begin
    int unsigned a;
    int unsigned ch;
    int unsigned rem;
    a        = 32'(addr_q);
    ch       = a / CH_SPAN;
    rem      = a % CH_SPAN;
    wr_comp  = 2'(rem / DEPTH);
    wr_index = BIW'(ch * DEPTH + (rem % DEPTH));
  end

  assign wr_en   = data_wr && in_range;
  assign wr_data = cfg_wdata[CW-1:0];

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && inc_q && in_range) |=> (addr_q == $past(addr_q) + 1'b1)); // R3

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !inc_q) |=> $stable(addr_q)); // R4

  AST_ADDR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !in_range) |=> ($stable(addr_q) && !in_range)); // R5

endmodule

// File: rtl/gamma_lut_bank.sv
module gamma_lut_bank #(
  parameter int NUM_CH = 3,
  parameter int DEPTH  = 256,
  parameter int CW     = 8,
  localparam int BIW   = $clog2(NUM_CH * DEPTH),
  localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [BIW-1:0] wr_index,
  input  logic [CW-1:0]  wr_data,
  input  logic [CHW-1:0] rd_ch,
  input  logic [CW-1:0]  rd_val,
  output logic [CW-1:0]  rd_data
);

  localparam int SIZE = NUM_CH * DEPTH;

  logic [CW-1:0] mem [SIZE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SIZE; i++) begin
        mem[i] <= CW'(i % DEPTH);
      end
    end else if (wr_en) begin
      mem[wr_index] <= wr_data;
    end
  end

  always_comb begin
    if (32'(rd_ch) < NUM_CH) begin
      rd_data = mem[BIW'(32'(rd_ch) * DEPTH + 32'(rd_val))];
    end else begin
      rd_data = rd_val;
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(wr_index)] == $past(wr_data))); // R2

endmodule

// File: rtl/gamma_lut_ctrl.sv
module gamma_lut_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic advance,
  output logic s1_valid,
  output logic out_valid
);

  logic s1_valid_d, out_valid_d;

  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  always_comb begin
    s1_valid_d  = s1_valid;
    out_valid_d = out_valid;
    if (advance) begin
      s1_valid_d  = in_valid;
      out_valid_d = s1_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      s1_valid  <= s1_valid_d;
      out_valid <= out_valid_d;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid); // R8

endmodule

// File: rtl/gamma_lut.sv
module gamma_lut
  import gamma_lut_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DEPTH  = 256,
  parameter int CW     = 8,
  parameter int CFG_W  = 16,
  localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int PIX_W = NUM_COMP * CW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [NUM_CH-1:0] gamma_en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CHW-1:0]   in_chan,
  input  logic [PIX_W-1:0] in_pixel,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_pixel
);

  localparam int BIW = $clog2(NUM_CH * DEPTH);

  // Reset: asserted at once, released on the clock.
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  // Register port.
  logic           wr_en;
  logic [1:0]     wr_comp;
  logic [BIW-1:0] wr_index;
  logic [CW-1:0]  wr_data;

  gamma_lut_regs #(
    .NUM_CH(NUM_CH), .DEPTH(DEPTH), .CW(CW), .CFG_W(CFG_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_s),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .wr_en(wr_en), .wr_comp(wr_comp), .wr_index(wr_index), .wr_data(wr_data)
  );

  // Pipeline control.
  logic advance, s1_valid;

  gamma_lut_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_s),
    .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .advance(advance),
    .s1_valid(s1_valid), .out_valid(out_valid)
  );

  // Stage 1: capture channel and pixel.
  logic [CHW-1:0]   s1_ch_q, s1_ch_d;
  logic [PIX_W-1:0] s1_pix_q, s1_pix_d;
  logic             s1_load;

  assign s1_load = advance && in_valid;

  always_comb begin
    s1_ch_d  = s1_ch_q;
    s1_pix_d = s1_pix_q;
    if (s1_load) begin
      s1_ch_d  = in_chan;
      s1_pix_d = in_pixel;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      s1_ch_q  <= '0;
      s1_pix_q <= '0;
    end else begin
      s1_ch_q  <= s1_ch_d;
      s1_pix_q <= s1_pix_d;
    end
  end

  // Lookup: one bank per component.
  logic [PIX_W-1:0] looked;

  for (genvar k = 0; k < NUM_COMP; k++) begin : g_comp
    localparam int LSB = (NUM_COMP - 1 - k) * CW;
    logic bank_wr;
    assign bank_wr = wr_en && (wr_comp == 2'(k));

    gamma_lut_bank #(
      .NUM_CH(NUM_CH), .DEPTH(DEPTH), .CW(CW)
    ) u_bank (
      .clk(clk), .rst_n(rst_s),
      .wr_en(bank_wr), .wr_index(wr_index), .wr_data(wr_data),
      .rd_ch(s1_ch_q), .rd_val(s1_pix_q[LSB +: CW]),
      .rd_data(looked[LSB +: CW])
    );
  end

  logic use_lut;
  always_comb begin
    use_lut = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (32'(s1_ch_q) == c) use_lut = gamma_en[c];
    end
  end

  // Stage 2: corrected pixel.
  logic [PIX_W-1:0] out_pix_q, out_pix_d;
  logic             s2_load;

  assign s2_load = advance && s1_valid;

  always_comb begin
    out_pix_d = out_pix_q;
    if (s2_load) out_pix_d = use_lut ? looked : s1_pix_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) out_pix_q <= '0;
    else        out_pix_q <= out_pix_d;
  end

  assign out_pixel = out_pix_q;

  AST_PIX_HOLD: assert property (@(posedge clk) disable iff (!rst_s)
    (out_valid && !out_ready) |=> $stable(out_pixel)); // R8

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(out_valid) |-> $past(in_valid && in_ready, 2)); // R7

endmodule

// File: tb/gamma_lut_test.sv
module gamma_lut_test;

  localparam int TOTAL = 2304;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic        cfg_sel;
  logic [15:0] cfg_wdata;
  logic [2:0]  gamma_en;
  logic        in_valid;
  logic        in_ready;
  logic [1:0]  in_chan;
  logic [23:0] in_pixel;
  logic        out_valid;
  logic        out_ready;
  logic [23:0] out_pixel;

  always #5 clk = ~clk;

  gamma_lut uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .gamma_en(gamma_en),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_chan(in_chan), .in_pixel(in_pixel),
    .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel)
  );

  logic [7:0]  ref_tab [TOTAL];
  int          ref_addr;
  bit          ref_inc;
  int          n_chk = 0;
  int          n_bad = 0;
  logic [23:0] exp_q [$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [23:0] expect_pix(int ch, logic [23:0] p, logic [2:0] en);
    if (ch >= 3 || !en[ch]) return p;
    return {ref_tab[ch*768 + p[23:16]],
            ref_tab[ch*768 + 256 + p[15:8]],
            ref_tab[ch*768 + 512 + p[7:0]]};
  endfunction

  task automatic cfg_write(logic sel, logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    if (!sel) begin
      ref_addr = int'(d[14:0]);
      ref_inc  = d[15];
    end else if (ref_addr < TOTAL) begin
      ref_tab[ref_addr] = d[7:0];
      if (ref_inc) ref_addr++;
    end
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic set_addr(int a, bit inc);
    cfg_write(1'b0, {inc, 15'(a)});
  endtask

  // Single pixel with an empty pipeline and out_ready held high.
  task automatic send_one(int ch, logic [23:0] p, string req);
    logic [23:0] e;
    @(negedge clk);
    in_valid = 1'b1; in_chan = 2'(ch); in_pixel = p; out_ready = 1'b1;
    e = expect_pix(ch, p, gamma_en);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7", 32'(out_valid), 32'd0, "out_valid one edge after accept");
    @(negedge clk);
    check("R7", 32'(out_valid), 32'd1, "out_valid two edges after accept");
    check(req, 32'(out_pixel), 32'(e), "pixel");
  endtask

  // Random stream with an irregular consumer.
  task automatic run_stream(int n, int ready_pct);
    bit          prev_stall = 0;
    logic [23:0] prev_pix = '0;
    logic [23:0] e;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (prev_stall) begin
        check("R8", 32'(out_valid), 32'd1, "valid held in stall");
        check("R8", 32'(out_pixel), 32'(prev_pix), "pixel held in stall");
      end
      if (!(in_valid && !in_ready)) begin
        in_valid = ($urandom_range(0, 3) != 0);
        in_chan  = 2'($urandom_range(0, 3));
        in_pixel = 24'($urandom);
      end
      out_ready = ($urandom_range(0, 99) < ready_pct);
      #1;
      check("R8", 32'(in_ready), 32'(out_ready || !out_valid), "in_ready rule");
      if (in_valid && in_ready) exp_q.push_back(expect_pix(int'(in_chan), in_pixel, gamma_en));
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check("R7", 32'd1, 32'd0, "unexpected output");
        else begin
          e = exp_q.pop_front();
          check("R2", 32'(out_pixel), 32'(e), "stream pixel");
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_pix   = out_pixel;
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    for (int i = 0; i < 20 && exp_q.size() > 0; i++) begin
      #1;
      if (out_valid) begin
        e = exp_q.pop_front();
        check("R2", 32'(out_pixel), 32'(e), "drained pixel");
      end
      @(negedge clk);
    end
    check("R7", 32'(exp_q.size()), 32'd0, "all pixels delivered");
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    logic [23:0] e_old;
    void'($urandom(32'h1A2B3C4D));
    for (int i = 0; i < TOTAL; i++) ref_tab[i] = 8'(i % 256);
    ref_addr = 0; ref_inc = 0;
    rst_n = 1'b0; cfg_wr = 0; cfg_sel = 0; cfg_wdata = '0;
    gamma_en = 3'b111; in_valid = 0; in_chan = '0; in_pixel = '0; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state and identity tables.
    check("R1", 32'(out_valid), 32'd0, "out_valid after reset");
    check("R1", 32'(in_ready), 32'd1, "in_ready after reset");
    send_one(0, 24'h12AB34, "R1");
    send_one(1, 24'hFF0080, "R1");
    send_one(2, 24'h00FF7F, "R1");

    // R3/R2: stream channel 1 green curve with auto-advance.
    set_addr(768 + 256, 1'b1);
    for (int i = 0; i < 256; i++) cfg_write(1'b1, 16'(8'(255 - i)));
    send_one(1, 24'h10203F, "R2");
    send_one(0, 24'h10203F, "R2");
    send_one(1, 24'h00FF00, "R3");

    // R6: bypass per channel and invalid channel index.
    gamma_en = 3'b101;
    send_one(1, 24'h10203F, "R6");
    gamma_en = 3'b111;
    send_one(3, 24'hA5A5A5, "R6");

    // R4: no auto-advance, repeated writes hit one entry.
    set_addr(0, 1'b0);
    cfg_write(1'b1, 16'h0011);
    cfg_write(1'b1, 16'h0022);
    send_one(0, 24'h000000, "R4");
    send_one(0, 24'h010000, "R4");

    // R5: last entry, then no wrap; out-of-range address ignored.
    set_addr(2303, 1'b1);
    cfg_write(1'b1, 16'h005A);
    cfg_write(1'b1, 16'h0077);
    set_addr(3000, 1'b0);
    cfg_write(1'b1, 16'h0099);
    send_one(2, 24'h0000FF, "R5");
    send_one(0, 24'h000000, "R5");

    // R9: write at the lookup edge of an accepted pixel.
    set_addr(5, 1'b0);
    @(negedge clk);
    in_valid = 1'b1; in_chan = 2'd0; in_pixel = 24'h050000; out_ready = 1'b1;
    e_old = expect_pix(0, 24'h050000, gamma_en);
    @(negedge clk);
    in_valid = 1'b0;
    cfg_wr = 1'b1; cfg_sel = 1'b1; cfg_wdata = 16'h00C3;
    ref_tab[5] = 8'hC3;
    @(negedge clk);
    cfg_wr = 1'b0;
    check("R9", 32'(out_valid), 32'd1, "valid for colliding pixel");
    check("R9", 32'(out_pixel), 32'(e_old), "colliding pixel sees old entry");
    send_one(0, 24'h050000, "R9");

    // Random table loads, some running off the end, then random streams.
    for (int b = 0; b < 6; b++) begin
      int start = $urandom_range(0, TOTAL - 1);
      int len   = $urandom_range(1, 300);
      set_addr(start, 1'b1);
      for (int i = 0; i < len; i++) cfg_write(1'b1, 16'($urandom));
    end
    set_addr(2400, 1'b1);
    cfg_write(1'b1, 16'h00EE);
    gamma_en = 3'b111;
    run_stream(1500, 70);
    gamma_en = 3'b010;
    run_stream(800, 40);
    gamma_en = 3'b111;
    run_stream(800, 100);

    summary();
  end

endmodule